// File: doc/BRIEF.md
# Exception Stack Frame Generator

When the processor takes an exception, this block builds a two-longword frame and pushes it onto the supervisor stack. A start strobe captures five inputs: the current supervisor stack pointer, the 16-bit status register, the 8-bit vector number, a 4-bit fault status code and the program counter to save. A select input picks the faulting or the next program counter.

The block rounds the stack pointer down to a longword boundary and reserves eight bytes below it. It records the discarded low address bits in a 4-bit format code. It then issues two 32-bit writes over a valid/ready port. The saved program counter goes first, to the higher word. The word with format, vector, fault status and status register goes second, to the new stack top.

After the second write is accepted, the block pulses done. Together with done it presents the new stack pointer and the vector table fetch address. It also raises an interrupt-sampling inhibit, which covers the handler's first instruction. The inhibit is released once that instruction retires.

Top module: `exc_frame_push`

## Requirements
- R1: After reset, wr_valid_o, done_o and irq_inhibit_o are all 0.
- R2: The new stack pointer equals the captured stack pointer with bits 1:0 cleared, minus 8, modulo 2^AW. It is therefore 8, 9, 10 or 11 below the original for low bits 00, 01, 10, 11.
- R3: Bits 31:28 of the second written word hold the format code 4 + ssp[1:0], giving 4, 5, 6 or 7.
- R4: The other fields of the second word sit as follows. Bits 27:26 hold fault status bits 3:2. Bits 25:18 hold the vector number. Bits 17:16 hold fault status bits 1:0. Bits 15:0 hold the status register.
- R5: The first write goes to new SP + 4 with the saved program counter. That value is pc_next_i when pc_sel_next_i is 1 and pc_fault_i when it is 0, both sampled at start.
- R6: The program-counter write is issued before the format/status write, which goes to the new SP. While wr_valid_o is high and wr_ready_i is low, address and data hold steady.
- R7: done_o is a one-cycle pulse in the cycle after the second write is accepted, and never earlier. new_ssp_o is updated with it.
- R8: vec_addr_o equals vbase_i + vector*4, with both values sampled at start. It is presented together with done_o.
- R9: A start strobe during a push is ignored: the frame in progress is written unchanged and no further write follows it. Inputs that change after start do not affect the frame.
- R10: irq_inhibit_o rises together with done_o. It stays high until a cycle with retire_i high and then drops in the next cycle.
- R11: new_ssp_o and vec_addr_o keep their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame push (sampled when idle) |
| ssp_i | input | AW | Current supervisor stack pointer |
| sr_i | input | 16 | Status register to save |
| pc_fault_i | input | 32 | PC of the faulting instruction |
| pc_next_i | input | 32 | PC of the following instruction |
| pc_sel_next_i | input | 1 | 1 saves pc_next_i, 0 saves pc_fault_i |
| vec_i | input | 8 | Exception vector number |
| fs_i | input | 4 | Fault status code |
| vbase_i | input | AW | Vector table base address |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 32 | Write data |
| done_o | output | 1 | Frame pushed (one-cycle pulse) |
| new_ssp_o | output | AW | Stack pointer after the push |
| vec_addr_o | output | AW | Vector table fetch address |
| irq_inhibit_o | output | 1 | Interrupt sampling inhibited |
| retire_i | input | 1 | Instruction retired |

## Verification
Directed frames walk all four stack-pointer low-bit patterns and the vector extremes 0, 64 and 255. They also cover a stack pointer near zero, where the subtraction wraps. These cases separate format encoding, alignment and offset arithmetic.

Random frames vary every field with a random ready pattern and expose field misplacement or a write order and stall handling that breaks under back-pressure. The bench changes the inputs and pulses start again during each push. This shows whether capture happens only at start and whether the strobe is ignored while busy. A random delay before retire shows whether the inhibit is held for the right span.

// File: rtl/exc_frame_push.sv
module exc_frame_push #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] ssp_i,
  input  logic [15:0]   sr_i,
  input  logic [31:0]   pc_fault_i,
  input  logic [31:0]   pc_next_i,
  input  logic          pc_sel_next_i,
  input  logic [7:0]    vec_i,
  input  logic [3:0]    fs_i,
  input  logic [AW-1:0] vbase_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic          done_o,
  output logic [AW-1:0] new_ssp_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          irq_inhibit_o,
  input  logic          retire_i
);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(8);
  localparam logic [AW-1:0] WORD_BYTES  = AW'(4);

  typedef enum logic [1:0] {S_IDLE, S_PC, S_FV} st_t;
  st_t st;

  logic [AW-1:0] frm_sp, tbl_addr;
  logic [31:0]   pc_q, fvsr_q;

  wire last = (st == S_FV) && wr_ready_i;
  wire [AW-1:0] sp_al = {ssp_i[AW-1:2], 2'b00} - FRAME_BYTES;
  wire [3:0] fmt = 4'd4 + {2'b00, ssp_i[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      frm_sp        <= '0;
      tbl_addr      <= '0;
      pc_q          <= '0;
      fvsr_q        <= '0;
      done_o        <= 1'b0;
      new_ssp_o     <= '0;
      vec_addr_o    <= '0;
      irq_inhibit_o <= 1'b0;
    end else begin
      done_o <= last;
      unique case (st)
        S_IDLE: if (start_i) begin
          frm_sp   <= sp_al;
          tbl_addr <= vbase_i + {{(AW-10){1'b0}}, vec_i, 2'b00};
          pc_q     <= pc_sel_next_i ? pc_next_i : pc_fault_i;
          fvsr_q   <= {fmt, fs_i[3:2], vec_i, fs_i[1:0], sr_i};
          st       <= S_PC;
        end
        S_PC:   if (wr_ready_i) st <= S_FV;
        S_FV:   if (wr_ready_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (last) begin
        new_ssp_o  <= frm_sp;
        vec_addr_o <= tbl_addr;
      end
      if (last)
        irq_inhibit_o <= 1'b1;
      else if (retire_i)
        irq_inhibit_o <= 1'b0;
    end
  end

  assign wr_valid_o = (st != S_IDLE);
  assign wr_addr_o  = (st == S_PC) ? frm_sp + WORD_BYTES : frm_sp;
  assign wr_data_o  = (st == S_PC) ? pc_q : fvsr_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_valid_o && wr_ready_i));

  // R10
  inhibit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> irq_inhibit_o);

  // R10
  inhibit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inhibit_o && retire_i && !last |=> !irq_inhibit_o);

  // R2
  ssp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> new_ssp_o[1:0] == 2'b00);

  // R11
  ssp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(new_ssp_o) && $stable(vec_addr_o) || done_o);
endmodule

// File: tb/tb_exc_frame_push.sv
module tb_exc_frame_push;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] ssp_i = '0;
  logic [15:0]   sr_i = '0;
  logic [31:0]   pc_fault_i = '0, pc_next_i = '0;
  logic          pc_sel_next_i = 1'b0;
  logic [7:0]    vec_i = '0;
  logic [3:0]    fs_i = '0;
  logic [AW-1:0] vbase_i = '0;
  logic          wr_valid_o, wr_ready_i = 1'b0;
  logic [AW-1:0] wr_addr_o;
  logic [31:0]   wr_data_o;
  logic          done_o;
  logic [AW-1:0] new_ssp_o, vec_addr_o;
  logic          irq_inhibit_o;
  logic          retire_i = 1'b0;

  int n_chk = 0, n_bad = 0;

  exc_frame_push #(.AW(AW)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_sp(input logic [AW-1:0] sp);
    return {sp[AW-1:2], 2'b00} - AW'(8);
  endfunction

  function automatic logic [31:0] exp_fv(input logic [AW-1:0] sp, input logic [3:0] fs,
                                         input logic [7:0] v, input logic [15:0] sr);
    logic [3:0] f = 4'd4 + {2'b00, sp[1:0]};
    return {f, fs[3:2], v, fs[1:0], sr};
  endfunction

  task automatic frame(input logic [AW-1:0] sp, input logic [15:0] sr,
                       input logic [31:0] pcf, input logic [31:0] pcn, input logic sel,
                       input logic [7:0] v, input logic [3:0] fs, input logic [AW-1:0] base,
                       input bit full_ready);
    logic [AW-1:0] nsp = exp_sp(sp);
    logic [AW-1:0] eaddr [2];
    logic [31:0]   edata [2];
    logic [AW-1:0] prev_ssp = new_ssp_o;
    int nwr = 0, guard = 0, wait_n;
    eaddr[0] = nsp + AW'(4); edata[0] = sel ? pcn : pcf;
    eaddr[1] = nsp;          edata[1] = exp_fv(sp, fs, v, sr);
    ssp_i = sp; sr_i = sr; pc_fault_i = pcf; pc_next_i = pcn; pc_sel_next_i = sel;
    vec_i = v; fs_i = fs; vbase_i = base; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (nwr < 2 && guard < 64) begin
      guard++;
      ssp_i = $urandom; sr_i = 16'($urandom); pc_fault_i = $urandom; pc_next_i = $urandom;
      pc_sel_next_i = 1'($urandom); vec_i = 8'($urandom); fs_i = 4'($urandom); vbase_i = $urandom;
      start_i = (guard == 1);                     // R9 start while busy
      wr_ready_i = full_ready ? 1'b1 : 1'($urandom);
      #1;
      chk("R6 valid during push", wr_valid_o, 1'b1);
      chk("R7 no early done", done_o, 1'b0);
      chk("R11 ssp held during push", new_ssp_o, prev_ssp);
      if (wr_ready_i) begin
        chk(nwr == 0 ? "R5 pc address" : "R2 frame address", wr_addr_o, eaddr[nwr]);
        chk(nwr == 0 ? "R5 pc data" : "R3/R4 format vector word", wr_data_o, edata[nwr]);
        nwr++;
      end
      @(negedge clk);
    end
    start_i = 1'b0; wr_ready_i = 1'b0;
    if (guard >= 64) chk("R6 push stalled", 0, 1);
    chk("R7 done pulse", done_o, 1'b1);
    chk("R2 new ssp", new_ssp_o, nsp);
    chk("R8 vector address", vec_addr_o, base + {22'd0, v, 2'b00});
    chk("R10 inhibit raised", irq_inhibit_o, 1'b1);
    @(negedge clk);
    chk("R7 done single cycle", done_o, 1'b0);
    chk("R9 no extra write", wr_valid_o, 1'b0);
    wait_n = $urandom % 4;
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk("R10 inhibit held", irq_inhibit_o, 1'b1);
      chk("R11 outputs held", {new_ssp_o, vec_addr_o}, {nsp, base + {22'd0, v, 2'b00}});
    end
    retire_i = 1'b1;
    @(negedge clk);
    retire_i = 1'b0;
    chk("R10 inhibit released", irq_inhibit_o, 1'b0);
    chk("R11 outputs held after retire", new_ssp_o, nsp);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", wr_valid_o, 1'b0);
    chk("R1 reset done", done_o, 1'b0);
    chk("R1 reset inhibit", irq_inhibit_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int lb = 0; lb < 4; lb++)
      frame(32'h2000_1000 | lb, 16'h2704, 32'h0000_4000, 32'h0000_4002, lb[0],
            8'd64, 4'(lb * 5), 32'h0000_0000, 1'b1);
    frame(32'h0000_0002, 16'hFFFF, 32'hDEAD_BEEF, 32'h1, 1'b0, 8'd255, 4'hF, 32'h0010_0000, 1'b0);
    frame(32'h0000_0003, 16'h0000, 32'h0, 32'hCAFE_F00C, 1'b1, 8'd0, 4'h0, 32'hFFFF_FF00, 1'b0);
    for (int i = 0; i < 200; i++)
      frame($urandom, 16'($urandom), $urandom, $urandom, 1'($urandom),
            8'($urandom), 4'($urandom), $urandom, (i % 5) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule